// File: doc/BRIEF.md
# Pulse Time Accumulator

This block totals how long an input signal spends high, spends low, or takes per full cycle. It counts in ticks of the system clock. The total runs over a programmable number of events, from 1 to 255. When that number is reached, the block gives a one-cycle completion pulse and holds the total until software asks for a new measurement. A caller gets a single-pulse or single-period measurement by asking for one event. Asking for many events and dividing the total outside the block gives an average.

The input is asynchronous. It passes through a two-stage synchronizer and an edge detector. A start pulse loads the configuration and clears the total. The block then waits for the selected starting edge before it counts anything. The total saturates at all ones, and a sticky overflow flag records that it did.

Top module: `pulse_accum`

## Requirements
- R1: While reset is held and right after it is released, `sum` is 0 and `done`, `busy` and `ovf` are 0.
- R2: `start` with a non-zero `evt_cnt` clears `sum` and `ovf`, raises `busy`, and latches `mode`, `edge_sel` and `evt_cnt`. Nothing is added until the first qualifying edge of the synchronized input arrives. That edge is rising when `edge_sel`=0 and falling when `edge_sel`=1.
- R3: With `mode`=2'b00 (high time), one is added for every clock in which the synchronized input is high. Each completed high pulse, ended by a falling edge, counts as one event.
- R4: With `mode`=2'b01 (low time), one is added for every clock in which the synchronized input is low. Each rising edge counts as one event.
- R5: With `mode`=2'b10 or 2'b11 (period), one is added for every clock after the starting edge. Each later qualifying edge counts as one event, so a period of P clocks adds P.
- R6: When the number of events reaches the latched `evt_cnt` (1 to 255), `done` is high for exactly one cycle and `busy` is low in that cycle. `sum` already shows the final total in that cycle.
- R7: After completion, `sum` stays unchanged and `done` stays low until the next accepted start, whatever the input does.
- R8: `start` with `evt_cnt`=0 while idle is ignored: `busy` stays low and `sum` keeps its value.
- R9: If the total would pass all ones, `sum` stays at all ones and `ovf` goes high. `ovf` stays high until the next accepted start.
- R10: An accepted `start` while `busy` abandons the measurement in progress and begins a new one with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the time base |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal to be measured |
| start | input | 1 | One-cycle request to begin a measurement |
| edge_sel | input | 1 | Starting edge: 0 rising, 1 falling |
| mode | input | 2 | 00 high time, 01 low time, 1x period |
| evt_cnt | input | CNT_W (8) | Number of events to accumulate, 1 to 255 |
| sum | output | SUM_W (32) | Accumulated total in clock ticks |
| done | output | 1 | One-cycle completion (interrupt) pulse |
| busy | output | 1 | Measurement armed or in progress |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `mode`, `edge_sel` and `evt_cnt` are stable in the cycle where `start` is high. They also assume `sig_in` changes slowly enough for every level to be held for at least one clock. The stimulus changes every input only on the falling clock edge and keeps each signal level for at least two clocks. A narrow-sum copy of the block is driven with the same inputs, so that saturation is reached within the run.

// File: rtl/pta_pkg.sv
`timescale 1ns/1ps
package pta_pkg;
   localparam logic [1:0] MODE_HIGH = 2'b00;
   localparam logic [1:0] MODE_LOW  = 2'b01;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_ARM  = 2'b01,
      ST_RUN  = 2'b10
   } pta_state_e;

   function automatic logic is_period(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/pta_edge.sv
`timescale 1ns/1ps
module pta_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic lvl,
   output logic lvl_q,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("pta_edge: STAGES must be at least 2");
   end

   for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= sig_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign lvl   = chain[LAST-1];
   assign lvl_q = chain[LAST];
   assign rise  = lvl & ~lvl_q;
   assign fall  = ~lvl & lvl_q;
endmodule

// File: rtl/pta_ctrl.sv
`timescale 1ns/1ps
module pta_ctrl
   import pta_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             edge_sel,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] evt_cnt,
   input  logic             rise,
   input  logic             fall,
   input  logic             lvl_q,
   output logic             clr,
   output logic             tick_en,
   output logic             done,
   output logic             busy
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   pta_state_e       st_q;
   logic [CNT_W-1:0] cnt_q, tgt_q;
   logic [1:0]       md_q;
   logic             esel_q, done_q;
   logic             start_ok, qual, evt;

   if (CNT_W < 1) begin : g_bad_cnt
      $error("pta_ctrl: CNT_W must be positive");
   end

   assign start_ok = start && (evt_cnt != '0);
   assign qual     = esel_q ? fall : rise;
   always_comb begin
      if (is_period(md_q))      evt = qual;
      else if (md_q == MODE_HIGH) evt = fall;
      else                      evt = rise;
   end

   always_comb begin
      tick_en = 1'b0;
      if (st_q == ST_RUN) begin
         if (is_period(md_q))        tick_en = 1'b1;
         else if (md_q == MODE_HIGH) tick_en = lvl_q;
         else                        tick_en = ~lvl_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         tgt_q  <= '0;
         md_q   <= MODE_HIGH;
         esel_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_ok) begin
            st_q   <= ST_ARM;
            cnt_q  <= '0;
            tgt_q  <= evt_cnt;
            md_q   <= mode;
            esel_q <= edge_sel;
         end else begin
            case (st_q)
               ST_ARM: if (qual) st_q <= ST_RUN;
               ST_RUN: if (evt) begin
                  if (cnt_q == tgt_q - ONE) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + ONE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign clr  = start_ok;
   assign done = done_q;
   assign busy = (st_q != ST_IDLE);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                // R6
   AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && evt_cnt == '0 && !busy) |=> !busy);                   // R8
   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && evt_cnt != '0) |=> (busy && !done));                  // R2
endmodule

// File: rtl/pta_acc.sv
`timescale 1ns/1ps
module pta_acc #(
   parameter int SUM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [SUM_W-1:0] sum,
   output logic             ovf
);
   localparam logic [SUM_W-1:0] ONE = {{(SUM_W-1){1'b0}}, 1'b1};

   logic [SUM_W-1:0] sum_q;
   logic             ovf_q;

   if (SUM_W < 2) begin : g_bad_sum
      $error("pta_acc: SUM_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr) begin
         sum_q <= '0;
         ovf_q <= 1'b0;
      end else if (inc) begin
         if (&sum_q) ovf_q <= 1'b1;
         else        sum_q <= sum_q + ONE;
      end
   end

   assign sum = sum_q;
   assign ovf = ovf_q;

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((&sum) && !clr) |=> (&sum));                                   // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);                                         // R9
   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum == '0 && !ovf));                                   // R2
endmodule

// File: rtl/pulse_accum.sv
`timescale 1ns/1ps
module pulse_accum #(
   parameter int SUM_W     = 32,
   parameter int CNT_W     = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sig_in,
   input  logic             start,
   input  logic             edge_sel,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] evt_cnt,
   output logic [SUM_W-1:0] sum,
   output logic             done,
   output logic             busy,
   output logic             ovf
);
   logic lvl, lvl_q, rise, fall, clr, tick_en;

   pta_edge #(.STAGES(SYNC_DEPTH)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
      .lvl(lvl), .lvl_q(lvl_q), .rise(rise), .fall(fall)
   );

   pta_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .edge_sel(edge_sel),
      .mode(mode), .evt_cnt(evt_cnt), .rise(rise), .fall(fall),
      .lvl_q(lvl_q), .clr(clr), .tick_en(tick_en), .done(done), .busy(busy)
   );

   pta_acc #(.SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tick_en),
      .sum(sum), .ovf(ovf)
   );

   AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(start && evt_cnt != '0)) |=> $stable(sum));        // R7
   AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !done);                                   // R7
endmodule

// File: tb/pulse_accum_bench.sv
`timescale 1ns/1ps
module pulse_accum_bench;
   localparam int SAT_W = 6;

   typedef struct packed {
      logic [1:0] md;
      logic       es;
      logic [7:0] n;
      logic [7:0] hi;
      logic [7:0] lo;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{2'b00, 1'b0, 8'd3,   8'd5, 8'd7},
      '{2'b01, 1'b0, 8'd4,   8'd3, 8'd6},
      '{2'b10, 1'b0, 8'd2,   8'd4, 8'd4},
      '{2'b11, 1'b1, 8'd1,   8'd6, 8'd3},
      '{2'b00, 1'b1, 8'd6,   8'd2, 8'd9},
      '{2'b01, 1'b1, 8'd255, 8'd2, 8'd3}
   };

   logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, start = 1'b0, edge_sel = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [7:0]  evt_cnt = 8'd0;
   logic [31:0] sum;
   logic [SAT_W-1:0] sum_s;
   logic done, busy, ovf, done_s, busy_s, ovf_s;

   int checks = 0, errors = 0, done_seen = 0;
   logic [31:0] done_sum = '0;
   logic prev_done = 1'b0;

   always #2 clk = ~clk;

   pulse_accum u_pulse_accum (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
      .edge_sel(edge_sel), .mode(mode), .evt_cnt(evt_cnt),
      .sum(sum), .done(done), .busy(busy), .ovf(ovf)
   );

   pulse_accum #(.SUM_W(SAT_W)) u_pulse_accum_sat (
      .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
      .edge_sel(edge_sel), .mode(mode), .evt_cnt(evt_cnt),
      .sum(sum_s), .done(done_s), .busy(busy_s), .ovf(ovf_s)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (done) begin
         done_seen++;
         done_sum = sum;
         chk(!busy, "R6 busy low at done", longint'(busy), 0);
      end
      if (done && prev_done) chk(1'b0, "R6 done single cycle", 2, 1);
      prev_done = done;
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic kick(input logic [1:0] m, input logic e, input logic [7:0] n);
      @(negedge clk);
      mode = m; edge_sel = e; evt_cnt = n; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc(3);
   endtask

   task automatic wave(input int hi, input int lo, input int periods);
      for (int p = 0; p < periods; p++) begin
         sig_in = 1'b1; cyc(hi);
         sig_in = 1'b0; cyc(lo);
      end
      cyc(8);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(4);
      // R1: state during and after reset
      chk(sum == 0 && !busy && !done && !ovf, "R1 in reset", longint'(sum), 0);
      rst_n = 1'b1;
      cyc(2);
      chk(sum == 0 && !busy && !done && !ovf, "R1 after reset", longint'({busy, done, ovf}), 0);

      // Table of modes: R3 high, R4 low, R5 period, R6 count, R7 hold
      for (int i = 0; i < 6; i++) begin
         automatic vec_t v = TBL[i];
         automatic int exp;
         case (v.md)
            2'b00:   exp = int'(v.n) * int'(v.hi);
            2'b01:   exp = int'(v.n) * int'(v.lo);
            default: exp = int'(v.n) * (int'(v.hi) + int'(v.lo));
         endcase
         kick(v.md, v.es, v.n);
         done_seen = 0;
         wave(int'(v.hi), int'(v.lo), int'(v.n) + 2);
         chk(done_seen == 1, "R6 one done per run", done_seen, 1);
         chk(done_sum == 32'(exp),
             v.md == 2'b00 ? "R3 high-time sum" : (v.md == 2'b01 ? "R4 low-time sum" : "R5 period sum"),
             longint'(done_sum), exp);
         chk(sum == 32'(exp) && !busy, "R7 sum held after done", longint'(sum), exp);
      end

      // R2: no accumulation before the qualifying edge
      kick(2'b10, 1'b0, 8'd2);
      cyc(10);
      chk(sum == 0 && busy, "R2 armed without counting", longint'(sum), 0);
      done_seen = 0;
      wave(4, 4, 4);
      chk(done_sum == 16 && done_seen == 1, "R2 sum after arming", longint'(done_sum), 16);

      // R10: restart while busy
      kick(2'b10, 1'b0, 8'd5);
      done_seen = 0;
      wave(4, 4, 2);
      chk(busy && done_seen == 0, "R10 first run still busy", longint'(busy), 1);
      kick(2'b10, 1'b0, 8'd2);
      wave(4, 4, 4);
      chk(done_seen == 1 && done_sum == 16, "R10 restarted total", longint'(done_sum), 16);

      // R9: saturation on the narrow copy, wide copy unaffected
      kick(2'b10, 1'b0, 8'd5);
      wave(10, 10, 7);
      chk(sum_s == '1 && ovf_s, "R9 saturated sum", longint'(sum_s), 63);
      chk(sum == 100 && !ovf, "R9 wide copy no overflow", longint'(sum), 100);
      kick(2'b10, 1'b0, 8'd1);
      chk(!ovf_s && sum_s == 0, "R9 ovf cleared by start", longint'(ovf_s), 0);
      wave(2, 2, 3);
      chk(sum_s == 4 && !ovf_s, "R9 fresh run after clear", longint'(sum_s), 4);

      // R8: zero event count is ignored
      done_seen = 0;
      kick(2'b10, 1'b0, 8'd0);
      chk(!busy, "R8 zero count stays idle", longint'(busy), 0);
      wave(3, 3, 3);
      chk(sum == 4 && done_seen == 0 && !busy, "R8 sum unchanged", longint'(sum), 4);

      // R7: input activity after completion leaves sum and done alone
      done_seen = 0;
      wave(5, 5, 4);
      chk(sum == 4 && done_seen == 0, "R7 idle activity ignored", longint'(sum), 4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule